// File: doc/BRIEF.md
# Switching Amplifier Protection and Mode Controller

This block supervises a two-channel switching power stage. Two control inputs and one external fault line select the mode: Sleep, Mute, Operating or Fault. The block gates the power-stage enable and the input-stage enable. While muted it forces the modulator to a 50% idle duty. It also runs the start-up window check that keeps the stage off while an output is tied to a supply rail.

Analog comparators outside the block report their results as digital flags. Each flag passes through a two-flop synchroniser inside the block. The flags cover a hard overcurrent, a soft current limit, an output-to-rail short, low supply, high supply, supply unbalance, over-temperature and the thermal foldback warning. The responses differ:
- A hard overcurrent disables the stage and starts a restart interval. The stage then retries after every interval for as long as the load short stays.
- A rail short found at the window check blocks restart until it clears.
- Supply faults hold the stage off and restart it one interval after they clear.
- Over-temperature shuts the stage off at once.
- Foldback only asks for reduced gain.

An active-low diagnostic output reports every protection except foldback. The block reads the same line back as the Fault-mode request, but only while it is not pulling the line low itself.

Top module: `amp_guard_ctrl`

## Requirements
- R1: With `pwr_up_i` low the block is in Sleep: `stage_en_o`, `input_en_o`, `idle50_o`, `limit_o` and `gain_red_o` are 0 and `diag_n_o` is 1. This is also the reset state.
- R2: With `pwr_up_i` high, no fault and the stage running, `engage_i` low gives Mute (`stage_en_o`=1, `idle50_o`=1, `input_en_o`=0). `engage_i` high gives Operating (`stage_en_o`=1, `input_en_o`=1, `idle50_o`=0).
- R3: Each start-up from Sleep, and each restart, first passes a window check. While `rail_short_i` is 1 the stage stays off and `diag_n_o` is 0. The stage turns on in the cycle after the check sees the flag clear.
- R4: A hard overcurrent (`ocp_trip_i`) while the stage runs turns the stage off in the next state update. The stage then stays off for exactly `RESTART_CYC` cycles before the window check runs again.
- R5: While `ocp_trip_i` stays high, the stage is re-enabled once per restart interval and tripped again each time.
- R6: If `rail_short_i` is high when a restart after overcurrent reaches the window check, the stage stays off with no periodic retry until the flag clears.
- R7: `ilim_i` asserts `limit_o` while the stage runs and causes no shutdown.
- R8: Any of `uv_i`, `ov_i` or `unbal_i` turns the stage off at once and holds `diag_n_o` low. After the last of these flags clears, the stage stays off `RESTART_CYC` more cycles and then passes the window check.
- R9: `otp_i` turns the stage off at once with `diag_n_o` low, and start-up resumes through the window check when it clears. `fold_i` only sets `gain_red_o` (while powered up) and leaves `diag_n_o` and the stage untouched.
- R10: After an overcurrent shutdown, `diag_n_o` is 0 for the first `DIAG_CYC` cycles of the restart interval and 1 for the rest of it.
- R11: When the diagnostic line reads low while `pwr_up_i` is high and the block is not driving `diag_n_o` low, the block enters Fault: the stage is off and `diag_n_o` stays 1. Release of the line restarts through the window check. The block ignores its own low drive for the synchroniser latency after it releases the line.
- R12: Every flag input reaches the outputs three clock edges after it is first sampled: two synchroniser flops, then the registered state and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_i | input | 1 | Power-up request (low = Sleep) |
| engage_i | input | 1 | Engage request (low = Mute, high = Operating) |
| diag_line_i | input | 1 | Level read back from the shared diagnostic line; low requests Fault |
| ocp_trip_i | input | 1 | Hard overcurrent flag (short across load or to a rail) |
| ilim_i | input | 1 | Soft current-limit flag (impedance drop) |
| rail_short_i | input | 1 | Window comparator: an output sits at a supply rail |
| uv_i | input | 1 | Supply below lower threshold |
| ov_i | input | 1 | Supply above upper threshold |
| unbal_i | input | 1 | Supply halves out of balance |
| otp_i | input | 1 | Over-temperature shutdown flag |
| fold_i | input | 1 | Thermal foldback warning |
| stage_en_o | output | 1 | Power stage switching enable |
| input_en_o | output | 1 | Input stage (audio path) enable |
| idle50_o | output | 1 | Force modulator to 50% idle duty |
| limit_o | output | 1 | Current limiting active |
| gain_red_o | output | 1 | Request gain reduction (foldback) |
| diag_n_o | output | 1 | Active-low diagnostic drive |

## Verification
The situation hardest to reach from the ports is a restart after overcurrent that lands on a rail short. The rail flag has to be present exactly when the interval ends, and it has to stay long enough to show that no retry follows. The bench raises `ocp_trip_i` and `rail_short_i` together and then holds the rail flag for several intervals while it counts rising edges of `stage_en_o`. The read-back of the shared diagnostic line needs care too. The bench models that line as the wired AND of its own pull-down and `diag_n_o`, so every low pulse the block drives comes back on `diag_line_i`, and a missing mask would show up as a spurious Fault.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;
  localparam int F_PU   = 0;
  localparam int F_ENG  = 1;
  localparam int F_DIAG = 2;
  localparam int F_OCP  = 3;
  localparam int F_ILIM = 4;
  localparam int F_RAIL = 5;
  localparam int F_UV   = 6;
  localparam int F_OV   = 7;
  localparam int F_UNB  = 8;
  localparam int F_OTP  = 9;
  localparam int F_FOLD = 10;
  localparam int NFLAG  = 11;

  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_CHECK = 3'd1,
    ST_RUN   = 3'd2,
    ST_OCW   = 3'd3,
    ST_SUPW  = 3'd4,
    ST_HOT   = 3'd5,
    ST_FAULT = 3'd6
  } guard_st_e;
endpackage

// File: rtl/agc_sync.sv
module agc_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[k] <= RST_VAL;
        else     chain[k] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[k] <= RST_VAL;
        else     chain[k] <= chain[k-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/agc_seq.sv
module agc_seq
  import amp_guard_pkg::*;
#(
  parameter int RESTART_CYC = 1000,
  localparam int CW = $clog2(RESTART_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] s,
  input  logic             self_mask,
  output guard_st_e        st_n,
  output logic [CW-1:0]    cnt_n
);
  localparam logic [CW-1:0] LAST = CW'(RESTART_CYC - 1);

  guard_st_e     st;
  logic [CW-1:0] cnt;
  logic          fault_req;
  logic          supply_bad;

  assign fault_req  = !s[F_DIAG] && !self_mask;
  assign supply_bad = s[F_UV] | s[F_OV] | s[F_UNB];

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (!s[F_PU]) begin
      st_n  = ST_SLEEP;
      cnt_n = '0;
    end else if (fault_req) begin
      st_n  = ST_FAULT;
      cnt_n = '0;
    end else if (s[F_OTP]) begin
      st_n  = ST_HOT;
      cnt_n = '0;
    end else if (supply_bad) begin
      st_n  = ST_SUPW;
      cnt_n = '0;
    end else begin
      unique case (st)
        ST_SLEEP, ST_FAULT, ST_HOT: begin
          st_n  = ST_CHECK;
          cnt_n = '0;
        end
        ST_SUPW, ST_OCW: begin
          if (cnt == LAST) begin
            st_n  = ST_CHECK;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_CHECK: st_n = s[F_RAIL] ? ST_CHECK : ST_RUN;
        ST_RUN: begin
          if (s[F_OCP]) begin
            st_n  = ST_OCW;
            cnt_n = '0;
          end
        end
        default: begin
          st_n  = ST_SLEEP;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_SLEEP;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  assert_rail_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && s[F_RAIL]) |=> (st != ST_RUN));

  assert_timer_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OCW && cnt != LAST) |=> (st != ST_RUN));
endmodule

// File: rtl/agc_out.sv
module agc_out
  import amp_guard_pkg::*;
#(
  parameter int DIAG_CYC = 500,
  parameter int CW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] s,
  input  guard_st_e        st_n,
  input  logic [CW-1:0]    cnt_n,
  output logic             self_mask,
  output logic             stage_en_o,
  output logic             input_en_o,
  output logic             idle50_o,
  output logic             limit_o,
  output logic             gain_red_o,
  output logic             diag_n_o
);
  localparam logic [CW-1:0] DIAG_L = CW'(DIAG_CYC);

  logic [SYNC_STAGES-1:0] low_hist;
  logic                   run_n;
  logic                   diag_low_n;

  assign run_n      = (st_n == ST_RUN);
  assign diag_low_n = (st_n == ST_HOT) || (st_n == ST_SUPW) ||
                      (st_n == ST_CHECK && s[F_RAIL]) ||
                      (st_n == ST_OCW && cnt_n < DIAG_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_en_o <= 1'b0;
      input_en_o <= 1'b0;
      idle50_o   <= 1'b0;
      limit_o    <= 1'b0;
      gain_red_o <= 1'b0;
      diag_n_o   <= 1'b1;
      low_hist   <= '0;
    end else begin
      stage_en_o <= run_n;
      input_en_o <= run_n && s[F_ENG];
      idle50_o   <= run_n && !s[F_ENG];
      limit_o    <= run_n && s[F_ILIM];
      gain_red_o <= s[F_PU] && s[F_FOLD];
      diag_n_o   <= !diag_low_n;
      low_hist   <= {low_hist[SYNC_STAGES-2:0], !diag_n_o};
    end
  end

  assign self_mask = !diag_n_o || (|low_hist);

  assert_sleep_R1: assert property (@(posedge clk) disable iff (rst)
    !s[F_PU] |=> (!stage_en_o && diag_n_o && !gain_red_o));

  assert_mute_R2: assert property (@(posedge clk) disable iff (rst)
    stage_en_o |-> $onehot({input_en_o, idle50_o}));

  assert_oc_off_R4: assert property (@(posedge clk) disable iff (rst)
    (stage_en_o && s[F_OCP]) |=> !stage_en_o);

  assert_supply_off_R8: assert property (@(posedge clk) disable iff (rst)
    (s[F_UV] || s[F_OV] || s[F_UNB]) |=> !stage_en_o);

  assert_hot_off_R9: assert property (@(posedge clk) disable iff (rst)
    s[F_OTP] |=> !stage_en_o);

  assert_limit_run_R7: assert property (@(posedge clk) disable iff (rst)
    limit_o |-> stage_en_o);
endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl
  import amp_guard_pkg::*;
#(
  parameter int RESTART_CYC = 10_000_000,
  parameter int DIAG_CYC    = 5_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_up_i,
  input  logic engage_i,
  input  logic diag_line_i,
  input  logic ocp_trip_i,
  input  logic ilim_i,
  input  logic rail_short_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic unbal_i,
  input  logic otp_i,
  input  logic fold_i,
  output logic stage_en_o,
  output logic input_en_o,
  output logic idle50_o,
  output logic limit_o,
  output logic gain_red_o,
  output logic diag_n_o
);
  localparam int CW = $clog2(RESTART_CYC + 1);
  localparam logic [NFLAG-1:0] SYNC_RST = NFLAG'(1) << F_DIAG;

  logic [NFLAG-1:0] raw;
  logic [NFLAG-1:0] s;
  guard_st_e        st_n;
  logic [CW-1:0]    cnt_n;
  logic             self_mask;

  always_comb begin
    raw         = '0;
    raw[F_PU]   = pwr_up_i;
    raw[F_ENG]  = engage_i;
    raw[F_DIAG] = diag_line_i;
    raw[F_OCP]  = ocp_trip_i;
    raw[F_ILIM] = ilim_i;
    raw[F_RAIL] = rail_short_i;
    raw[F_UV]   = uv_i;
    raw[F_OV]   = ov_i;
    raw[F_UNB]  = unbal_i;
    raw[F_OTP]  = otp_i;
    raw[F_FOLD] = fold_i;
  end

  agc_sync #(.W(NFLAG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(s)
  );

  agc_seq #(.RESTART_CYC(RESTART_CYC)) u_seq (
    .clk(clk), .rst(rst), .s(s), .self_mask(self_mask),
    .st_n(st_n), .cnt_n(cnt_n)
  );

  agc_out #(.DIAG_CYC(DIAG_CYC), .CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_out (
    .clk(clk), .rst(rst), .s(s), .st_n(st_n), .cnt_n(cnt_n),
    .self_mask(self_mask),
    .stage_en_o(stage_en_o), .input_en_o(input_en_o), .idle50_o(idle50_o),
    .limit_o(limit_o), .gain_red_o(gain_red_o), .diag_n_o(diag_n_o)
  );

  assert_fold_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (s[F_FOLD] && stage_en_o && !s[F_OCP] && !s[F_OTP] && !s[F_UV] &&
     !s[F_OV] && !s[F_UNB] && s[F_PU] && s[F_DIAG]) |=> diag_n_o);
endmodule

// File: tb/amp_guard_ctrl_bench.sv
`timescale 1ns/1ps
module amp_guard_ctrl_bench;
  localparam int RC = 40;
  localparam int DC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pu = 0, eng = 0, ext_n = 1, ocp = 0, ilim = 0, rail = 0;
  logic uv = 0, ov = 0, unb = 0, otp = 0, fold = 0;
  logic stage_en, input_en, idle50, limit_q, gain_red, diag_n;
  logic line;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  assign line = ext_n & diag_n;

  amp_guard_ctrl #(.RESTART_CYC(RC), .DIAG_CYC(DC)) u_amp_guard_ctrl (
    .clk(clk), .rst(rst), .pwr_up_i(pu), .engage_i(eng), .diag_line_i(line),
    .ocp_trip_i(ocp), .ilim_i(ilim), .rail_short_i(rail), .uv_i(uv), .ov_i(ov),
    .unbal_i(unb), .otp_i(otp), .fold_i(fold),
    .stage_en_o(stage_en), .input_en_o(input_en), .idle50_o(idle50),
    .limit_o(limit_q), .gain_red_o(gain_red), .diag_n_o(diag_n)
  );

  // Behavioural reference: mode codes 0 sleep,1 check,2 run,3 oc wait,4 supply wait,5 hot,6 fault
  int m_mode = 0;
  int m_wait = 0;
  logic [10:0] p1, p2;
  logic e_stage = 0, e_in = 0, e_idle = 0, e_lim = 0, e_gain = 0, e_diag = 1;
  int cyc = 0;

  always @(posedge clk) begin
    logic [10:0] now;
    int nm, nw;
    logic sp, se, sd, so, sl, sr, ssup, sot, sf;
    now = {fold, otp, unb, ov, uv, rail, ilim, ocp, ext_n, eng, pu};
    cyc++;
    if (rst) begin
      m_mode = 0; m_wait = 0;
      p1 = 11'b100; p2 = 11'b100;
      e_stage = 0; e_in = 0; e_idle = 0; e_lim = 0; e_gain = 0; e_diag = 1;
    end else begin
      sp = p2[0]; se = p2[1]; sd = p2[2]; so = p2[3]; sl = p2[4]; sr = p2[5];
      ssup = p2[6] | p2[7] | p2[8]; sot = p2[9]; sf = p2[10];
      nm = m_mode; nw = m_wait;
      if (!sp) begin nm = 0; nw = 0; end
      else if (!sd) begin nm = 6; nw = 0; end
      else if (sot) begin nm = 5; nw = 0; end
      else if (ssup) begin nm = 4; nw = 0; end
      else if (m_mode == 0 || m_mode == 5 || m_mode == 6) begin nm = 1; nw = 0; end
      else if (m_mode == 3 || m_mode == 4) begin
        if (m_wait == RC - 1) begin nm = 1; nw = 0; end else nw = m_wait + 1;
      end
      else if (m_mode == 1) nm = sr ? 1 : 2;
      else if (m_mode == 2 && so) begin nm = 3; nw = 0; end
      m_mode = nm; m_wait = nw;
      e_stage = (nm == 2);
      e_in    = (nm == 2) && se;
      e_idle  = (nm == 2) && !se;
      e_lim   = (nm == 2) && sl;
      e_gain  = sp && sf;
      e_diag  = !((nm == 5) || (nm == 4) || (nm == 1 && sr) || (nm == 3 && nw < DC));
    end
    p2 = p1; p1 = now;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cmp1(string req, string nm, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, nm, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      cmp1(cur_req, "stage_en", stage_en, e_stage);
      cmp1(cur_req, "input_en", input_en, e_in);
      cmp1(cur_req, "idle50",   idle50,   e_idle);
      cmp1(cur_req, "limit",    limit_q,  e_lim);
      cmp1(cur_req, "gain_red", gain_red, e_gain);
      cmp1(cur_req, "diag_n",   diag_n,   e_diag);
    end
  end

  int rises = 0;
  logic last_stage = 0;
  always @(negedge clk) begin
    if (stage_en && !last_stage) rises++;
    last_stage = stage_en;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string nm, logic act, logic exp);
    cmp1(req, nm, act, exp);
  endtask

  task automatic chk_int(string req, string nm, int act, int lo);
    compared++;
    if (act < lo) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, nm, act, lo);
    end
  endtask

  initial begin
    step(3);
    chk("R1", "reset stage", stage_en, 1'b0);
    chk("R1", "reset diag", diag_n, 1'b1);
    rst = 1'b0;
    step(4);
    chk("R1", "sleep stage", stage_en, 1'b0);

    cur_req = "R2";
    pu = 1;
    step(6);
    chk("R2", "mute stage", stage_en, 1'b1);
    chk("R2", "mute idle", idle50, 1'b1);
    chk("R2", "mute input", input_en, 1'b0);
    eng = 1;
    step(2);
    chk("R12", "engage not yet visible", input_en, 1'b0);
    step(1);
    chk("R12", "engage after three edges", input_en, 1'b1);
    chk("R2", "operate idle", idle50, 1'b0);

    cur_req = "R7";
    ilim = 1; step(6);
    chk("R7", "limit on", limit_q, 1'b1);
    chk("R7", "no shutdown", stage_en, 1'b1);
    ilim = 0; step(6);

    cur_req = "R9";
    fold = 1; step(6);
    chk("R9", "gain reduce", gain_red, 1'b1);
    chk("R9", "fold diag quiet", diag_n, 1'b1);
    fold = 0; step(4);

    cur_req = "R4";
    ocp = 1; step(2); ocp = 0;
    step(8);
    chk("R4", "oc stage off", stage_en, 1'b0);
    chk("R10", "oc diag low", diag_n, 1'b0);
    step(20);
    chk("R10", "diag released", diag_n, 1'b1);
    chk("R4", "still off", stage_en, 1'b0);
    step(30);
    chk("R4", "restarted", stage_en, 1'b1);

    cur_req = "R5";
    rises = 0;
    ocp = 1; step(200); ocp = 0;
    chk_int("R5", "retries", rises, 3);
    step(RC + 10);
    chk("R5", "back on", stage_en, 1'b1);

    cur_req = "R6";
    ocp = 1; rail = 1; step(3); ocp = 0;
    rises = 0;
    step(4 * RC);
    chk_int("R6", "no retry (neg)", 0, rises);
    chk("R6", "stays off", stage_en, 1'b0);
    chk("R6", "window diag low", diag_n, 1'b0);
    cur_req = "R3";
    rail = 0; step(6);
    chk("R3", "on after clear", stage_en, 1'b1);

    cur_req = "R8";
    uv = 1; step(30);
    chk("R8", "uv off", stage_en, 1'b0);
    chk("R8", "uv diag", diag_n, 1'b0);
    uv = 0; step(RC - 5);
    chk("R8", "waiting", stage_en, 1'b0);
    step(12);
    chk("R8", "uv restart", stage_en, 1'b1);
    ov = 1; step(5); ov = 0; step(RC + 10);
    unb = 1; step(5);
    chk("R8", "unbal off", stage_en, 1'b0);
    unb = 0; step(RC + 10);
    chk("R8", "unbal restart", stage_en, 1'b1);

    cur_req = "R9";
    otp = 1; step(5);
    chk("R9", "hot off", stage_en, 1'b0);
    chk("R9", "hot diag", diag_n, 1'b0);
    otp = 0; step(8);
    chk("R9", "hot recover", stage_en, 1'b1);

    cur_req = "R11";
    ext_n = 0; step(6);
    chk("R11", "fault off", stage_en, 1'b0);
    chk("R11", "fault diag not driven", diag_n, 1'b1);
    ext_n = 1; step(8);
    chk("R11", "fault released", stage_en, 1'b1);

    cur_req = "R3";
    pu = 0; step(6);
    chk("R1", "sleep again", stage_en, 1'b0);
    rail = 1; pu = 1; step(20);
    chk("R3", "startup held", stage_en, 1'b0);
    chk("R3", "startup diag", diag_n, 1'b0);
    rail = 0; step(6);
    chk("R3", "startup done", stage_en, 1'b1);

    step(5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule